// File: doc/BRIEF.md
# Multiplexed LCD Row/Column Scanner

This block produces the drive-phase pattern for a 40-output multiplexed liquid-crystal driver. It steps through the common (row) lines, toggles a frame-polarity signal once per full frame, and for every output gives a symbolic level code plus a polarity bit. An analog stage outside the block turns these into voltages. A per-pixel display store holds one bit per segment. Writes go first to a shadow copy and reach the visible copy only at a frame-polarity edge, so the pattern never changes in the middle of a polarity phase and no DC term builds up.

The multiplex ratio (2, 4 or 8) decides how many of the low-numbered outputs act as rows. A column-only strap turns every output into a column driver for cascaded slave devices. In that mode the row stepping follows an external frame-sync pulse, which keeps all devices in a chain aligned. Two blanking sources, a strobe pin and a command bit, force every segment off at once. The display also stays blank after reset until every row in use has been written and applied.

Top module: `lcd_mux_scanner`

## Requirements
- R1: After reset, frame_pol is 0, the row index is 0, and every column output shows the off code 2'b11 (the display is blank).
- R2: With col_only low, outputs 0..n-1 are rows, where n is 2, 4 or 8 for mux_sel 0, 1 or 2 (mux_sel 3 also gives 8). Exactly the output equal to the current row shows select (2'b00). Every other row output shows non-select (2'b01).
- R3: With col_only high, no output shows select or non-select. All 40 outputs are column drivers.
- R4: A column output i shows on (2'b10) when bit i of the applied store row for the current row index is 1. It shows off (2'b11) when that bit is 0.
- R5: drv_pol of an output equals frame_pol for the select, non-select and off codes. It equals the inverse of frame_pol for the on code.
- R6: With col_only low, the row index advances every ROW_PERIOD clocks and wraps to 0 after row n-1. frame_pol toggles exactly at that wrap, so one frame lasts n*ROW_PERIOD clocks.
- R7: With col_only high, the row index and frame_pol advance only on a clock where frame_sync is high. Otherwise they hold.
- R8: While blank_in or blank_cmd is high, every column output shows off in the same cycle. When both are low, the store contents show again.
- R9: A write (wr_en, wr_row, wr_data, where wr_data bit i belongs to output i) changes the visible pattern only at the next frame_pol toggle.
- R10: The display stays blank until every row 0..n-1 has been written at least once and a frame_pol toggle has then applied the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mux_sel | input | 2 | Multiplex ratio: 0 gives 2 rows, 1 gives 4, 2 or 3 give 8 |
| col_only | input | 1 | Column-only strap for cascaded slaves |
| frame_sync | input | 1 | External row-step pulse, used in column-only mode |
| blank_in | input | 1 | Strobe; high blanks the display |
| blank_cmd | input | 1 | Blank command bit |
| wr_en | input | 1 | Store write enable |
| wr_row | input | 3 | Store row written |
| wr_data | input | 40 | Pixel bits for that row, bit i for output i |
| frame_pol | output | 1 | Frame polarity |
| drv_lvl | output | 80 | Level code per output, bits 2i+1:2i for output i |
| drv_pol | output | 40 | Polarity bit per output |

## Verification
The assertions check several properties on every cycle. No more than one row is selected, and none is in column-only mode. A selected row is in phase with frame_pol. No segment is on while blanked. The visible store changes only at an apply edge. frame_pol changes only when the row index returns to zero. The row position holds in column-only mode when no sync pulse arrives. Only the bench scenarios can show the exact code and polarity on all 40 outputs across two frames for each ratio and mode, the frame length in clocks, the delayed effect of writes, and the release from the blank state after a full first write.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

   typedef enum logic [1:0] {
      LVL_SEL  = 2'b00,
      LVL_NSEL = 2'b01,
      LVL_ON   = 2'b10,
      LVL_OFF  = 2'b11
   } drv_lvl_e;

   // rows in use for a ratio code, clipped to the row capacity
   function automatic int unsigned rows_for_mode(input logic [1:0] code, input int unsigned cap);
      int unsigned r;
      case (code)
         2'd0:    r = 2;
         2'd1:    r = 4;
         default: r = 8;
      endcase
      return (r > cap) ? cap : r;
   endfunction

endpackage

// File: rtl/lcd_row_timer.sv
module lcd_row_timer
   import lcd_scan_pkg::*;
#(
   parameter int ROW_PERIOD = 256,
   parameter int MAX_ROWS   = 8,
   localparam int RW        = $clog2(MAX_ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mux_sel,
   input  logic          col_only,
   input  logic          frame_sync,
   output logic [RW-1:0] row_idx,
   output logic [RW:0]   n_rows,
   output logic          frame_pol,
   output logic          frame_edge
);

   logic tick;
   logic step;
   logic last;

   assign n_rows = (RW+1)'(rows_for_mode(mux_sel, MAX_ROWS));

   generate
      if (ROW_PERIOD == 1) begin : g_no_pres
         assign tick = 1'b1;
      end else begin : g_pres
         localparam int PW = $clog2(ROW_PERIOD);
         logic [PW-1:0] pres;
         assign tick = (pres == PW'(ROW_PERIOD - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pres <= '0;
            else if (col_only || tick)
               pres <= '0;
            else
               pres <= pres + 1'b1;
         end
      end
   endgenerate

   assign step       = col_only ? frame_sync : tick;
   assign last       = ({1'b0, row_idx} >= (n_rows - 1'b1));
   assign frame_edge = step & last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_idx   <= '0;
         frame_pol <= 1'b0;
      end else if (step) begin
         row_idx   <= last ? '0 : row_idx + 1'b1;
         frame_pol <= frame_pol ^ last;
      end
   end

   AST_FRAME_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(frame_pol) |-> (row_idx == '0)); // R6

   AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (col_only && !frame_sync) |=> ($stable(row_idx) && $stable(frame_pol))); // R7

endmodule

// File: rtl/lcd_pixel_store.sv
module lcd_pixel_store #(
   parameter int NUM_OUT  = 40,
   parameter int MAX_ROWS = 8,
   localparam int RW      = $clog2(MAX_ROWS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [RW-1:0]      wr_row,
   input  logic [NUM_OUT-1:0] wr_data,
   input  logic               apply,
   input  logic [RW:0]        n_rows,
   input  logic [RW-1:0]      rd_row,
   output logic [NUM_OUT-1:0] rd_bits,
   output logic               valid
);

   logic [NUM_OUT-1:0]          shadow [MAX_ROWS];
   logic [NUM_OUT-1:0]          active [MAX_ROWS];
   logic [MAX_ROWS-1:0]         wmask;
   logic [MAX_ROWS-1:0]         need;
   logic [MAX_ROWS*NUM_OUT-1:0] active_flat;

   genvar r;
   generate
      for (r = 0; r < MAX_ROWS; r++) begin : g_row
         assign need[r] = ((RW+1)'(r) < n_rows);
         assign active_flat[r*NUM_OUT +: NUM_OUT] = active[r];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shadow[r] <= '0;
               wmask[r]  <= 1'b0;
            end else if (wr_en && (wr_row == RW'(r))) begin
               shadow[r] <= wr_data;
               wmask[r]  <= 1'b1;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               active[r] <= '0;
            else if (apply)
               active[r] <= shadow[r];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         valid <= 1'b0;
      else if (apply && ((wmask | ~need) == '1))
         valid <= 1'b1;
   end

   assign rd_bits = active[rd_row];

   AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> $stable(active_flat)); // R9

   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> valid); // R10

endmodule

// File: rtl/lcd_drive_map.sv
module lcd_drive_map
   import lcd_scan_pkg::*;
#(
   parameter int NUM_OUT  = 40,
   parameter int MAX_ROWS = 8,
   localparam int RW      = $clog2(MAX_ROWS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [RW-1:0]        row_idx,
   input  logic [RW:0]          n_rows,
   input  logic                 frame_pol,
   input  logic                 col_only,
   input  logic                 blank,
   input  logic [NUM_OUT-1:0]   pix_bits,
   output logic [2*NUM_OUT-1:0] drv_lvl,
   output logic [NUM_OUT-1:0]   drv_pol
);

   logic [NUM_OUT-1:0] sel_vec;
   logic [NUM_OUT-1:0] row_vec;

   genvar i;
   generate
      for (i = 0; i < NUM_OUT; i++) begin : g_out
         if (i < MAX_ROWS) begin : g_dual
            assign row_vec[i] = !col_only && ((RW+1)'(i) < n_rows);
            assign sel_vec[i] = row_vec[i] && (row_idx == RW'(i));
         end else begin : g_col
            assign row_vec[i] = 1'b0;
            assign sel_vec[i] = 1'b0;
         end

         always_comb begin
            if (row_vec[i]) begin
               drv_lvl[2*i +: 2] = sel_vec[i] ? LVL_SEL : LVL_NSEL;
               drv_pol[i]        = frame_pol;
            end else if (!blank && pix_bits[i]) begin
               drv_lvl[2*i +: 2] = LVL_ON;
               drv_pol[i]        = ~frame_pol;
            end else begin
               drv_lvl[2*i +: 2] = LVL_OFF;
               drv_pol[i]        = frame_pol;
            end
         end
      end
   endgenerate

   AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_vec)); // R2

   AST_COL_NO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      col_only |-> (row_vec == '0)); // R3

endmodule

// File: rtl/lcd_mux_scanner.sv
module lcd_mux_scanner
   import lcd_scan_pkg::*;
#(
   parameter int NUM_OUT    = 40,
   parameter int MAX_ROWS   = 8,
   parameter int ROW_PERIOD = 256,
   localparam int RW        = $clog2(MAX_ROWS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           mux_sel,
   input  logic                 col_only,
   input  logic                 frame_sync,
   input  logic                 blank_in,
   input  logic                 blank_cmd,
   input  logic                 wr_en,
   input  logic [RW-1:0]        wr_row,
   input  logic [NUM_OUT-1:0]   wr_data,
   output logic                 frame_pol,
   output logic [2*NUM_OUT-1:0] drv_lvl,
   output logic [NUM_OUT-1:0]   drv_pol
);

   generate
      if (NUM_OUT <= MAX_ROWS) begin : g_bad_out
         $error("NUM_OUT must exceed MAX_ROWS");
      end
      if (MAX_ROWS < 8 || (MAX_ROWS & (MAX_ROWS - 1)) != 0) begin : g_bad_rows
         $error("MAX_ROWS must be a power of two of at least 8");
      end
      if (ROW_PERIOD < 1) begin : g_bad_period
         $error("ROW_PERIOD must be at least 1");
      end
   endgenerate

   logic [RW-1:0]      row_idx;
   logic [RW:0]        n_rows;
   logic               frame_edge;
   logic [NUM_OUT-1:0] pix_bits;
   logic               valid;
   logic               blank;

   lcd_row_timer #(.ROW_PERIOD(ROW_PERIOD), .MAX_ROWS(MAX_ROWS)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .mux_sel    (mux_sel),
      .col_only   (col_only),
      .frame_sync (frame_sync),
      .row_idx    (row_idx),
      .n_rows     (n_rows),
      .frame_pol  (frame_pol),
      .frame_edge (frame_edge)
   );

   lcd_pixel_store #(.NUM_OUT(NUM_OUT), .MAX_ROWS(MAX_ROWS)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_row  (wr_row),
      .wr_data (wr_data),
      .apply   (frame_edge),
      .n_rows  (n_rows),
      .rd_row  (row_idx),
      .rd_bits (pix_bits),
      .valid   (valid)
   );

   assign blank = blank_in | blank_cmd | ~valid;

   lcd_drive_map #(.NUM_OUT(NUM_OUT), .MAX_ROWS(MAX_ROWS)) u_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .row_idx   (row_idx),
      .n_rows    (n_rows),
      .frame_pol (frame_pol),
      .col_only  (col_only),
      .blank     (blank),
      .pix_bits  (pix_bits),
      .drv_lvl   (drv_lvl),
      .drv_pol   (drv_pol)
   );

   logic [NUM_OUT-1:0] on_vec;
   genvar k;
   generate
      for (k = 0; k < NUM_OUT; k++) begin : g_chk
         assign on_vec[k] = (drv_lvl[2*k +: 2] == LVL_ON);
         if (k < MAX_ROWS) begin : g_selpol
            AST_SEL_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
               (drv_lvl[2*k +: 2] == LVL_SEL) |-> (drv_pol[k] == frame_pol)); // R5
         end
      end
   endgenerate

   AST_BLANK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_in || blank_cmd) |-> (on_vec == '0)); // R8

endmodule

// File: tb/tb_lcd_mux_scanner.sv
module tb_lcd_mux_scanner;

   localparam int P  = 16;
   localparam int NO = 40;

   typedef struct packed {
      logic [1:0]  mux;
      logic        col;
      logic [39:0] seed;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{mux: 2'd0, col: 1'b0, seed: 40'hA5_3C0F_F01E},
      '{mux: 2'd1, col: 1'b0, seed: 40'h12_3456_789A},
      '{mux: 2'd2, col: 1'b0, seed: 40'hFF_00FF_0F0F},
      '{mux: 2'd2, col: 1'b1, seed: 40'h81_4224_1899},
      '{mux: 2'd3, col: 1'b0, seed: 40'h5A_A55A_A5C3},
      '{mux: 2'd0, col: 1'b1, seed: 40'h0F_F0C3_3C77}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mux_sel = 2'd0;
   logic col_only = 1'b0, frame_sync = 1'b0, blank_in = 1'b0, blank_cmd = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_row = '0;
   logic [NO-1:0] wr_data = '0;
   logic frame_pol;
   logic [2*NO-1:0] drv_lvl;
   logic [NO-1:0] drv_pol;

   always #5 clk = ~clk;

   lcd_mux_scanner #(.NUM_OUT(NO), .MAX_ROWS(8), .ROW_PERIOD(P)) dut (
      .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .col_only(col_only),
      .frame_sync(frame_sync), .blank_in(blank_in), .blank_cmd(blank_cmd),
      .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
      .frame_pol(frame_pol), .drv_lvl(drv_lvl), .drv_pol(drv_pol)
   );

   int tests = 0, fails = 0;
   logic done = 1'b0;
   logic [NO-1:0] m_shadow [8];
   logic [NO-1:0] m_active [8];
   logic [7:0]    m_wmask = '0;
   logic          m_valid = 1'b0;
   logic          m_fr = 1'b0;
   int            cur_row = 0;

   function automatic int rows_of(input logic [1:0] m);
      return (m == 2'd0) ? 2 : (m == 2'd1) ? 4 : 8;
   endfunction

   function automatic logic [3*NO-1:0] expect_vec(input int n, input logic col, input int row,
                                                  input logic fr, input logic blank,
                                                  input logic [NO-1:0] bits);
      logic [2*NO-1:0] l;
      logic [NO-1:0]   p;
      for (int i = 0; i < NO; i++) begin
         if (!col && i < n) begin
            l[2*i +: 2] = (i == row) ? 2'b00 : 2'b01;
            p[i] = fr;
         end else if (!blank && bits[i]) begin
            l[2*i +: 2] = 2'b10;
            p[i] = ~fr;
         end else begin
            l[2*i +: 2] = 2'b11;
            p[i] = fr;
         end
      end
      return {l, p};
   endfunction

   task automatic check_now(input string tag);
      logic [3*NO-1:0] e;
      #1;
      e = expect_vec(rows_of(mux_sel), col_only, cur_row, m_fr,
                     blank_in | blank_cmd | ~m_valid, m_active[cur_row]);
      tests++;
      if ({drv_lvl, drv_pol} !== e || frame_pol !== m_fr) begin
         fails++;
         $display("FAIL %s row %0d: got lvl=%h pol=%h fr=%b, exp lvl=%h pol=%h fr=%b",
                  tag, cur_row, drv_lvl, drv_pol, frame_pol, e[3*NO-1:NO], e[NO-1:0], m_fr);
      end
   endtask

   task automatic apply_model();
      int n;
      n = rows_of(mux_sel);
      for (int r = 0; r < 8; r++) m_active[r] = m_shadow[r];
      if ((m_wmask | ~((8'd1 << n) - 8'd1)) == 8'hFF) m_valid = 1'b1;
   endtask

   task automatic pulse_sync();
      @(negedge clk); frame_sync = 1'b1;
      @(negedge clk); frame_sync = 1'b0;
   endtask

   task automatic advance_row();
      int n;
      n = rows_of(mux_sel);
      if (col_only) pulse_sync(); else repeat (P) @(negedge clk);
      if (cur_row >= n - 1) begin
         cur_row = 0; m_fr = ~m_fr; apply_model();
      end else cur_row++;
   endtask

   task automatic sync_frame(input string tag);
      logic start;
      logic seen;
      start = frame_pol;
      seen = 1'b0;
      for (int k = 0; k < 400 && !seen; k++) begin
         if (col_only) pulse_sync(); else @(negedge clk);
         if (frame_pol !== start) seen = 1'b1;
      end
      tests++;
      if (!seen) begin
         fails++;
         $display("FAIL %s R6/R7: frame_pol stuck at %b, exp a toggle", tag, start);
      end
      m_fr = frame_pol; cur_row = 0; apply_model();
   endtask

   task automatic write_row(input int r, input logic [NO-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_row = 3'(r); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      m_shadow[r] = d; m_wmask[r] = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, got timeout exp completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < 8; r++) begin m_shadow[r] = '0; m_active[r] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_now("R1 reset blank state");

      // R10: partial first write keeps the display blank
      col_only = 1'b1;
      @(negedge clk);
      write_row(0, 40'hFF_FFFF_FFFF);
      sync_frame("R10 partial");
      check_now("R10 blank after partial write");
      write_row(1, 40'h00_0000_FFFF);
      sync_frame("R10 full");
      check_now("R10 R4 shown after full write");
      advance_row();
      check_now("R4 R5 row 1 col-only");

      // R7: no sync pulses, nothing moves
      repeat (20) @(negedge clk);
      check_now("R7 hold without frame_sync");

      // R8: blanking sources
      blank_in = 1'b1;
      check_now("R8 blank_in forces off");
      blank_in = 1'b0; blank_cmd = 1'b1;
      check_now("R8 blank_cmd forces off");
      blank_cmd = 1'b0;
      check_now("R8 contents return");

      // R9: write not visible until frame edge
      write_row(1, 40'hAB_CDEF_0123);
      check_now("R9 write held back");
      advance_row();
      check_now("R9 write applied after toggle");

      // table walk over ratios and modes
      foreach (VECS[v]) begin
         int n;
         @(negedge clk);
         mux_sel = VECS[v].mux; col_only = VECS[v].col;
         n = rows_of(VECS[v].mux);
         sync_frame("table align");
         for (int r = 0; r < 8; r++)
            write_row(r, (VECS[v].seed << r) | (VECS[v].seed >> (NO - r)) ^ 40'(r));
         sync_frame("table apply");
         for (int s = 0; s < 2 * n + 1; s++) begin
            check_now(VECS[v].col ? "R3 R4 R5 R7 table" : "R2 R4 R5 R6 table");
            advance_row();
         end
      end

      // R6: frame length in internal mode
      @(negedge clk);
      col_only = 1'b0; mux_sel = 2'd1;
      sync_frame("R6 align");
      begin
         int cnt;
         logic st;
         cnt = 0; st = frame_pol;
         while (frame_pol === st && cnt < 1000) begin
            @(negedge clk); cnt++;
         end
         tests++;
         if (cnt != 4 * P) begin
            fails++;
            $display("FAIL R6 frame length: got %0d exp %0d", cnt, 4 * P);
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule